// File: doc/BRIEF.md
# ADC Result Stream Formatter

This block turns the results of a multi-channel analog-to-digital converter into a stream of 16-bit half-words for a DMA engine. A trigger pulse starts one acquisition walk. In classical mode the walk visits the enabled channels, either in ascending channel number or in the order of a programmable list of sequence slots. For each channel it visits, the block asks the converter for one result and then emits one half-word. In touchscreen-only mode each walk asks for an X position and then a Y position.

Every emitted half-word carries a byte address. The address starts at a base value and moves forward by two for each half-word the downstream side accepts, so successive triggers fill a packed buffer. An optional tag puts the channel number in the top four bits of each word, which makes the buffer easy to parse and to check. In touchscreen mode an averaging setting thins the output, so only one trigger in every 2^avg produces data. A trigger that arrives while a walk is still running is dropped, and a sticky flag records that it happened.

Top module: `adc_stream_fmt`

## Requirements
- R1: Each half-word holds the conversion result right aligned in bits [9:0], and bits [11:10] are always zero.
- R2: When `tag_i` is 1, bits [15:12] hold the channel code of the result. Touchscreen X uses code 14 and Y uses code 15. When `tag_i` is 0, bits [15:12] are zero.
- R3: With `useq_i` = 0, a trigger emits one word for each channel set in `chan_en_i`, in ascending channel order.
- R4: With `useq_i` = 1, a trigger visits slots 0 to SEQ_N-1 in order. Slot k is `seq_i[4k+3:4k]`. A slot emits a word only if it names a channel below NCH whose enable bit is set. A channel named in several slots is emitted once for each such slot.
- R5: After reset the address is BASE_ADDR. It grows by 2 on each accepted word (`hw_valid_o` and `hw_ready_i` both high) and holds otherwise. With three channels enabled, trigger n starts at the first address plus 6·(n-1).
- R6: When `ts_mode_i` is 1 or 3 and `chan_en_i` is zero, an emitting trigger produces two words: X (code 14) first, then Y (code 15). When `ts_mode_i` is 0 or 2 and `chan_en_i` is zero, a trigger produces nothing.
- R7: In touchscreen-only mode, count the touchscreen triggers accepted since reset, starting from 0. A trigger emits only when that count modulo 2^`ts_avg_i` is zero. A skipped trigger emits nothing and does not set the overrun flag.
- R8: A trigger that arrives while `busy_o` is high is ignored, so the walk in progress keeps its word count. It also sets `overrun_o`, which stays set until reset.
- R9: While `hw_valid_o` is high and `hw_ready_i` is low, `hw_valid_o`, `hw_data_o` and `hw_addr_o` keep their values on the next cycle.
- R10: After reset, `hw_valid_o`, `conv_req_o`, `busy_o` and `overrun_o` are 0.
- R11: While `conv_req_o` is high and `conv_rdy_i` is low, the request and `conv_ch_o` keep their values on the next cycle. One accepted conversion produces exactly one output word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_i | input | 1 | One-cycle trigger pulse that starts a walk |
| chan_en_i | input | NCH | Classical channel enable mask |
| seq_i | input | 4·SEQ_N | Sequence slots, slot k in bits [4k+3:4k] |
| useq_i | input | 1 | 1 = walk the sequence slots, 0 = ascending order |
| tag_i | input | 1 | 1 = put the channel code in bits [15:12] |
| ts_mode_i | input | 2 | Touchscreen mode; 1 or 3 selects X/Y pairs when no channel is enabled |
| ts_avg_i | input | 2 | Touchscreen thinning exponent |
| conv_req_o | output | 1 | Conversion request to the converter |
| conv_ch_o | output | 4 | Channel code being requested |
| conv_rdy_i | input | 1 | Converter result valid for the current request |
| conv_data_i | input | RES_W | Converter result |
| hw_valid_o | output | 1 | Output half-word valid |
| hw_ready_i | input | 1 | Downstream accepts the half-word |
| hw_data_o | output | 16 | Output half-word |
| hw_addr_o | output | ADDR_W | Byte address of the output half-word |
| busy_o | output | 1 | A walk is in progress |
| overrun_o | output | 1 | Sticky flag for a dropped trigger |

## Verification
The bench builds the block with twelve channels, eight sequence slots and a base address of 0x0100. This lets a full twelve-channel walk run, lets the sequence list hold duplicate slots and slots that name channels beyond the last one, and shows that addressing starts from a nonzero base. The converter model answers only every other cycle, and the downstream ready signal drops one cycle in three, so every walk contains both conversion waits and output stalls. The touchscreen thinning counter carries over between configurations, which tests the modulo behaviour across changes of the averaging setting.

// File: rtl/adc_fmt_pkg.sv
package adc_fmt_pkg;
    localparam int TAG_W  = 4;
    localparam int WORD_W = 16;

    localparam logic [TAG_W-1:0] TS_X_CODE = 4'd14;
    localparam logic [TAG_W-1:0] TS_Y_CODE = 4'd15;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SCAN,
        ST_CONV,
        ST_OUT
    } fmt_state_e;
endpackage

// File: rtl/adc_chan_pick.sv
module adc_chan_pick
    import adc_fmt_pkg::*;
#(
    parameter int NCH   = 12,
    parameter int SEQ_N = 8,
    parameter int POS_W = 4
) (
    input  logic [POS_W-1:0]       pos_i,
    input  logic                   ts_i,
    input  logic                   useq_i,
    input  logic [NCH-1:0]         chan_en_i,
    input  logic [SEQ_N*TAG_W-1:0] seq_i,
    output logic [TAG_W-1:0]       ch_o,
    output logic                   hit_o,
    output logic                   last_o
);
    logic [TAG_W-1:0] cls_ch;
    logic             cls_hit;

    // channel named by the current position
    always_comb begin
        cls_ch = '0;
        if (useq_i) begin
            for (int k = 0; k < SEQ_N; k++) begin
                if (pos_i == POS_W'(k)) cls_ch = seq_i[k*TAG_W +: TAG_W];
            end
        end else begin
            for (int k = 0; k < NCH; k++) begin
                if (pos_i == POS_W'(k)) cls_ch = TAG_W'(k);
            end
        end
    end

    // enable lookup; codes at or above NCH never hit
    always_comb begin
        cls_hit = 1'b0;
        for (int i = 0; i < NCH; i++) begin
            if (cls_ch == TAG_W'(i)) cls_hit = chan_en_i[i];
        end
    end

    always_comb begin
        if (ts_i) begin
            ch_o   = (pos_i == '0) ? TS_X_CODE : TS_Y_CODE;
            hit_o  = 1'b1;
            last_o = (pos_i == POS_W'(1));
        end else begin
            ch_o   = cls_ch;
            hit_o  = cls_hit;
            last_o = useq_i ? (pos_i == POS_W'(SEQ_N-1)) : (pos_i == POS_W'(NCH-1));
        end
    end
endmodule

// File: rtl/adc_word_pack.sv
module adc_word_pack
    import adc_fmt_pkg::*;
#(
    parameter int RES_W = 10
) (
    input  logic              tag_en_i,
    input  logic [TAG_W-1:0]  ch_i,
    input  logic [RES_W-1:0]  res_i,
    output logic [WORD_W-1:0] word_o
);
    always_comb begin
        word_o = '0;
        word_o[RES_W-1:0] = res_i;
        if (tag_en_i) word_o[WORD_W-1 -: TAG_W] = ch_i;
    end
endmodule

// File: rtl/adc_ts_gate.sv
module adc_ts_gate #(
    parameter int CNT_W = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       step_i,
    input  logic [1:0] avg_i,
    output logic       emit_i_ok
);
    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W-1:0] span_mask;

    always_comb begin
        span_mask = CNT_W'(({{CNT_W{1'b0}}, 1'b1} << avg_i) - 1'b1);
        emit_i_ok = ((cnt_q & span_mask) == '0);
        cnt_d     = step_i ? cnt_q + CNT_W'(1) : cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/adc_stream_fmt.sv
module adc_stream_fmt
    import adc_fmt_pkg::*;
#(
    parameter int               NCH       = 12,
    parameter int               SEQ_N     = 8,
    parameter int               RES_W     = 10,
    parameter int               ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = '0
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   trig_i,
    input  logic [NCH-1:0]         chan_en_i,
    input  logic [SEQ_N*4-1:0]     seq_i,
    input  logic                   useq_i,
    input  logic                   tag_i,
    input  logic [1:0]             ts_mode_i,
    input  logic [1:0]             ts_avg_i,
    output logic                   conv_req_o,
    output logic [3:0]             conv_ch_o,
    input  logic                   conv_rdy_i,
    input  logic [RES_W-1:0]       conv_data_i,
    output logic                   hw_valid_o,
    input  logic                   hw_ready_i,
    output logic [15:0]            hw_data_o,
    output logic [ADDR_W-1:0]      hw_addr_o,
    output logic                   busy_o,
    output logic                   overrun_o
);
    localparam int POS_MAX = (NCH > SEQ_N) ? NCH : SEQ_N;
    localparam int POS_W   = (POS_MAX > 2) ? $clog2(POS_MAX) : 1;

    typedef struct packed {
        fmt_state_e        st;
        logic [POS_W-1:0]  pos;
        logic              ts;
        logic [TAG_W-1:0]  ch;
        logic [WORD_W-1:0] word;
        logic [ADDR_W-1:0] addr;
        logic              ovr;
    } regs_t;

    regs_t r_d, r_q;

    logic [TAG_W-1:0]  pick_ch;
    logic              pick_hit, pick_last;
    logic [WORD_W-1:0] packed_word;
    logic              ts_only, ts_step, ts_emit;

    adc_chan_pick #(.NCH(NCH), .SEQ_N(SEQ_N), .POS_W(POS_W)) u_pick (
        .pos_i    (r_q.pos),
        .ts_i     (r_q.ts),
        .useq_i   (useq_i),
        .chan_en_i(chan_en_i),
        .seq_i    (seq_i),
        .ch_o     (pick_ch),
        .hit_o    (pick_hit),
        .last_o   (pick_last)
    );

    adc_word_pack #(.RES_W(RES_W)) u_pack (
        .tag_en_i(tag_i),
        .ch_i    (r_q.ch),
        .res_i   (conv_data_i),
        .word_o  (packed_word)
    );

    adc_ts_gate #(.CNT_W(3)) u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .step_i   (ts_step),
        .avg_i    (ts_avg_i),
        .emit_i_ok(ts_emit)
    );

    always_comb begin
        r_d     = r_q;
        ts_step = 1'b0;
        ts_only = ((ts_mode_i == 2'd1) || (ts_mode_i == 2'd3)) && (chan_en_i == '0);

        unique case (r_q.st)
            ST_IDLE: begin
                if (trig_i) begin
                    if (ts_only) begin
                        ts_step = 1'b1;
                        if (ts_emit) begin
                            r_d.st  = ST_SCAN;
                            r_d.pos = '0;
                            r_d.ts  = 1'b1;
                        end
                    end else if (chan_en_i != '0) begin
                        r_d.st  = ST_SCAN;
                        r_d.pos = '0;
                        r_d.ts  = 1'b0;
                    end
                end
            end
            ST_SCAN: begin
                if (pick_hit) begin
                    r_d.st = ST_CONV;
                    r_d.ch = pick_ch;
                end else if (pick_last) begin
                    r_d.st = ST_IDLE;
                end else begin
                    r_d.pos = r_q.pos + POS_W'(1);
                end
            end
            ST_CONV: begin
                if (conv_rdy_i) begin
                    r_d.word = packed_word;
                    r_d.st   = ST_OUT;
                end
            end
            ST_OUT: begin
                if (hw_ready_i) begin
                    r_d.addr = r_q.addr + ADDR_W'(2);
                    if (pick_last) begin
                        r_d.st = ST_IDLE;
                    end else begin
                        r_d.pos = r_q.pos + POS_W'(1);
                        r_d.st  = ST_SCAN;
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase

        if (trig_i && (r_q.st != ST_IDLE)) r_d.ovr = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.st   <= ST_IDLE;
            r_q.addr <= BASE_ADDR;
        end else begin
            r_q <= r_d;
        end
    end

    assign conv_req_o = (r_q.st == ST_CONV);
    assign conv_ch_o  = r_q.ch;
    assign hw_valid_o = (r_q.st == ST_OUT);
    assign hw_data_o  = r_q.word;
    assign hw_addr_o  = r_q.addr;
    assign busy_o     = (r_q.st != ST_IDLE);
    assign overrun_o  = r_q.ovr;

    // R9
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hw_valid_o && !hw_ready_i |=> hw_valid_o && $stable(hw_data_o) && $stable(hw_addr_o));

    // R5
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hw_valid_o && hw_ready_i |=> hw_addr_o == $past(hw_addr_o) + ADDR_W'(2));

    // R5
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(hw_valid_o && hw_ready_i) |=> $stable(hw_addr_o));

    // R8
    overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overrun_o |=> overrun_o);

    // R8
    overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && trig_i |=> overrun_o);

    // R1
    gap_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hw_valid_o |-> hw_data_o[11:10] == 2'b00);

    // R11
    conv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req_o && !conv_rdy_i |=> conv_req_o && $stable(conv_ch_o));

    // R11
    conv_to_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req_o && conv_rdy_i |=> hw_valid_o && !conv_req_o);
endmodule

// File: tb/tb_adc_stream_fmt.sv
module tb_adc_stream_fmt;
    localparam int          NCH   = 12;
    localparam int          SEQ_N = 8;
    localparam logic [15:0] BASE  = 16'h0100;

    typedef struct packed {
        logic [11:0] mask;
        logic [31:0] seq;
        logic        useq;
        logic        tag;
        logic [1:0]  mode;
        logic [1:0]  avg;
        logic [3:0]  ntrig;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{mask: 12'h160, seq: 32'h0,        useq: 1'b0, tag: 1'b1, mode: 2'd0, avg: 2'd0, ntrig: 4'd3},
        '{mask: 12'h160, seq: 32'h0,        useq: 1'b0, tag: 1'b0, mode: 2'd0, avg: 2'd0, ntrig: 4'd2},
        '{mask: 12'hFFF, seq: 32'h0,        useq: 1'b0, tag: 1'b1, mode: 2'd0, avg: 2'd0, ntrig: 4'd1},
        '{mask: 12'h160, seq: 32'hB10D8658, useq: 1'b1, tag: 1'b1, mode: 2'd0, avg: 2'd0, ntrig: 4'd2},
        '{mask: 12'h803, seq: 32'hB10D8658, useq: 1'b1, tag: 1'b0, mode: 2'd0, avg: 2'd0, ntrig: 4'd1},
        '{mask: 12'h000, seq: 32'h0,        useq: 1'b0, tag: 1'b1, mode: 2'd1, avg: 2'd0, ntrig: 4'd2},
        '{mask: 12'h000, seq: 32'h0,        useq: 1'b0, tag: 1'b0, mode: 2'd3, avg: 2'd2, ntrig: 4'd6},
        '{mask: 12'h000, seq: 32'h0,        useq: 1'b0, tag: 1'b1, mode: 2'd2, avg: 2'd0, ntrig: 4'd2},
        '{mask: 12'h000, seq: 32'h0,        useq: 1'b0, tag: 1'b1, mode: 2'd0, avg: 2'd0, ntrig: 4'd1}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              trig_i = 1'b0;
    logic [NCH-1:0]    chan_en_i = '0;
    logic [SEQ_N*4-1:0] seq_i = '0;
    logic              useq_i = 1'b0;
    logic              tag_i = 1'b0;
    logic [1:0]        ts_mode_i = '0;
    logic [1:0]        ts_avg_i = '0;
    logic              conv_req_o;
    logic [3:0]        conv_ch_o;
    logic              conv_rdy_i;
    logic [9:0]        conv_data_i;
    logic              hw_valid_o;
    logic              hw_ready_i = 1'b1;
    logic [15:0]       hw_data_o;
    logic [15:0]       hw_addr_o;
    logic              busy_o;
    logic              overrun_o;

    int   checks = 0;
    int   fails  = 0;
    int   cyc    = 0;
    int   seed   = 0;
    int   ts_cnt = 0;
    logic cv_tog = 1'b0;

    logic [15:0] exp_w [32];
    int          exp_n = 0;
    int          got = 0;
    logic [15:0] exp_addr = BASE;
    logic [15:0] first_addr = '0;
    string       cur_req = "R3";

    logic        stall_pend = 1'b0;
    logic [15:0] stall_data = '0;
    logic [15:0] stall_addr = '0;

    always #10 clk = ~clk;

    function automatic logic [9:0] data10(logic [3:0] ch, int s);
        return 10'((int'(ch) * 73 + s * 11) & 1023);
    endfunction

    always_comb begin
        conv_data_i = data10(conv_ch_o, seed);
        conv_rdy_i  = conv_req_o & cv_tog;
    end

    adc_stream_fmt #(
        .NCH(NCH), .SEQ_N(SEQ_N), .RES_W(10), .ADDR_W(16), .BASE_ADDR(BASE)
    ) dut (
        .clk(clk), .rst_n(rst_n), .trig_i(trig_i), .chan_en_i(chan_en_i),
        .seq_i(seq_i), .useq_i(useq_i), .tag_i(tag_i), .ts_mode_i(ts_mode_i),
        .ts_avg_i(ts_avg_i), .conv_req_o(conv_req_o), .conv_ch_o(conv_ch_o),
        .conv_rdy_i(conv_rdy_i), .conv_data_i(conv_data_i), .hw_valid_o(hw_valid_o),
        .hw_ready_i(hw_ready_i), .hw_data_o(hw_data_o), .hw_addr_o(hw_addr_o),
        .busy_o(busy_o), .overrun_o(overrun_o)
    );

    task automatic chk(bit ok, string req, string what, int act, int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    function automatic logic [15:0] mkword(logic [3:0] ch, logic tag, int s);
        logic [15:0] w;
        w = {6'b0, data10(ch, s)};
        if (tag) w[15:12] = ch;
        return w;
    endfunction

    task automatic push(logic [3:0] ch, logic tag);
        exp_w[exp_n] = mkword(ch, tag, seed);
        exp_n++;
    endtask

    task automatic build_exp(vec_t v);
        bit tsonly;
        exp_n  = 0;
        tsonly = ((v.mode == 2'd1) || (v.mode == 2'd3)) && (v.mask == '0);
        if (tsonly) begin
            if ((ts_cnt % (1 << v.avg)) == 0) begin
                push(4'd14, v.tag);
                push(4'd15, v.tag);
            end
            ts_cnt++;
        end else if (v.mask != '0) begin
            if (v.useq) begin
                for (int k = 0; k < SEQ_N; k++) begin
                    logic [3:0] c;
                    c = v.seq[k*4 +: 4];
                    if (int'(c) < NCH && v.mask[c]) push(c, v.tag);
                end
            end else begin
                for (int c = 0; c < NCH; c++) begin
                    if (v.mask[c]) push(4'(c), v.tag);
                end
            end
        end
    endtask

    task automatic tick();
        @(negedge clk);
        cyc++;
        cv_tog     = ~cv_tog;
        hw_ready_i = (cyc % 3) != 1;
        if (stall_pend) begin
            // R9
            chk(hw_valid_o && hw_data_o == stall_data && hw_addr_o == stall_addr,
                "R9", "stall hold", int'(hw_data_o), int'(stall_data));
        end
        stall_pend = hw_valid_o && !hw_ready_i;
        stall_data = hw_data_o;
        stall_addr = hw_addr_o;
        if (hw_valid_o && hw_ready_i) begin
            if (got < exp_n) begin
                chk(hw_data_o == exp_w[got], cur_req, "word", int'(hw_data_o), int'(exp_w[got]));
            end else begin
                chk(1'b0, cur_req, "extra word", got + 1, exp_n);
            end
            // R5
            chk(hw_addr_o == exp_addr, "R5", "address", int'(hw_addr_o), int'(exp_addr));
            if (got == 0) first_addr = hw_addr_o;
            exp_addr = exp_addr + 16'd2;
            got++;
        end
    endtask

    task automatic apply(vec_t v);
        chan_en_i = v.mask;
        seq_i     = v.seq;
        useq_i    = v.useq;
        tag_i     = v.tag;
        ts_mode_i = v.mode;
        ts_avg_i  = v.avg;
    endtask

    task automatic run_trigger(vec_t v, int early_retrig);
        seed++;
        build_exp(v);
        got    = 0;
        trig_i = 1'b1;
        tick();
        trig_i = 1'b0;
        for (int n = 0; n < 600; n++) begin
            if (early_retrig != 0 && n == early_retrig) begin
                trig_i = 1'b1;
                tick();
                trig_i = 1'b0;
            end
            tick();
            if (!busy_o && !hw_valid_o) break;
        end
        chk(got == exp_n, cur_req, "word count", got, exp_n);
    endtask

    function automatic string req_of(int i);
        case (i)
            0: return "R2";
            1: return "R1";
            2: return "R3";
            3: return "R4";
            4: return "R4";
            5: return "R6";
            6: return "R7";
            default: return "R6";
        endcase
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        tick();
        tick();
        rst_n = 1'b1;
        tick();
        // R10 reset state
        chk(!hw_valid_o, "R10", "valid after reset", int'(hw_valid_o), 0);
        chk(!conv_req_o, "R10", "conv_req after reset", int'(conv_req_o), 0);
        chk(!busy_o,     "R10", "busy after reset", int'(busy_o), 0);
        chk(!overrun_o,  "R10", "overrun after reset", int'(overrun_o), 0);
        chk(hw_addr_o == BASE, "R5", "base address", int'(hw_addr_o), int'(BASE));

        for (int i = 0; i < NV; i++) begin
            logic [15:0] start_a;
            apply(VECS[i]);
            cur_req = req_of(i);
            tick();
            start_a = exp_addr;
            for (int t = 0; t < int'(VECS[i].ntrig); t++) begin
                run_trigger(VECS[i], 0);
                if (i == 0) begin
                    // R5: trigger n starts at start + 6*(n-1)
                    chk(first_addr == start_a + 16'(6 * t), "R5", "trigger start",
                        int'(first_addr), int'(start_a + 16'(6 * t)));
                end
            end
        end
        // R8: nothing so far overlapped a walk
        chk(!overrun_o, "R8", "no overrun yet", int'(overrun_o), 0);

        // R8: a retrigger during a full walk is dropped and flagged
        apply(VECS[2]);
        cur_req = "R8";
        tick();
        run_trigger(VECS[2], 4);
        chk(overrun_o == 1'b1, "R8", "overrun set", int'(overrun_o), 1);
        tick();
        tick();
        chk(overrun_o == 1'b1, "R8", "overrun sticky", int'(overrun_o), 1);

        // R11: one conversion per word, with a slow converter already in use
        cur_req = "R11";
        apply(VECS[3]);
        tick();
        run_trigger(VECS[3], 0);

        // R10: a second reset clears the flag and the address
        rst_n = 1'b0;
        tick();
        rst_n    = 1'b1;
        ts_cnt   = 0;
        exp_addr = BASE;
        stall_pend = 1'b0;
        tick();
        chk(!overrun_o, "R10", "overrun cleared", int'(overrun_o), 0);
        chk(hw_addr_o == BASE, "R10", "address back to base", int'(hw_addr_o), int'(BASE));

        // R7: counter restarts at zero after reset
        cur_req = "R7";
        apply(VECS[6]);
        tick();
        for (int t = 0; t < 5; t++) run_trigger(VECS[6], 0);
        chk(!overrun_o, "R7", "skipped triggers do not flag", int'(overrun_o), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule